// File: doc/BRIEF.md
# Six-State Hardwired Control Sequencer

This block is the control unit of a very small accumulator machine. A one-hot timing ring steps through six states, T1 to T6, one state per clock. In every state the block drives a 12-bit control word that steers the datapath around it. That datapath holds the program counter, the address register, the memory, the instruction register, the accumulator, the adder/subtractor, the operand register and the output register.

The first three states fetch an instruction and are the same for every opcode. The last three states execute the instruction, and their words depend on the 4-bit opcode taken from the instruction register. A halt instruction stops the ring and holds it stopped until the clear input is asserted.

The control word mixes polarities. Its bits run from bit 11 down to bit 0 as follows:

| Bit | Name | Function | Active level |
|-----|------|----------|--------------|
| 11 | pc_inc | count up the program counter | high |
| 10 | pc_drive | program counter onto the bus | high |
| 9 | mar_load_n | load the address register | low |
| 8 | mem_drive_n | memory onto the bus | low |
| 7 | ir_load_n | load the instruction register | low |
| 6 | ir_drive_n | instruction register low nibble onto the bus | low |
| 5 | acc_load_n | load the accumulator | low |
| 4 | acc_drive | accumulator onto the bus | high |
| 3 | alu_sub | subtract select | high |
| 2 | alu_drive | ALU onto the bus | high |
| 1 | breg_load_n | load the operand register | low |
| 0 | out_load_n | load the output register | low |

With nothing asserted the word is 0x3E3.

Top module: `seq_ctrl_top`

## Requirements
- R1: While rst_n is low, tstate is 6'b000001 (T1), halted is 0 and ctl_word is 0x5E3. rst_n takes effect without waiting for a clock edge.
- R2: Outside halt, tstate is one-hot and advances one state per rising clock edge: T1, T2, T3, T4, T5, T6, then back to T1. Bit i of tstate stands for state T(i+1).
- R3: For any opcode, ctl_word is 0x5E3 in T1, 0xBE3 in T2 and 0x263 in T3.
- R4: For opcode 4'b0000 (load), ctl_word is 0x1A3 in T4, 0x2C3 in T5 and 0x3E3 in T6.
- R5: For opcode 4'b0001 (add), ctl_word is 0x1A3 in T4, 0x2E1 in T5 and 0x3C7 in T6.
- R6: For opcode 4'b0010 (subtract), ctl_word is 0x1A3 in T4, 0x2E1 in T5 and 0x3CF in T6.
- R7: For opcode 4'b1110 (output), ctl_word is 0x3F2 in T4, 0x3E3 in T5 and 0x3E3 in T6.
- R8: For opcode 4'b1111 (halt), ctl_word is 0x3E3 in T4. At the next edge halted becomes 1. From then on, tstate stays at T4 and ctl_word stays 0x3E3 until clear.
- R9: Asserting rst_n releases halt and returns the ring to T1. After rst_n rises, tstate stays at T1 through two rising edges and moves to T2 at the third.
- R10: Any other opcode produces 0x3E3 in T4, T5 and T6, and the ring does not stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | clear; asserts asynchronously, active low |
| opcode | input | 4 | upper nibble of the instruction register |
| ctl_word | output | 12 | control word, bit 11 = pc_inc down to bit 0 = out_load_n |
| tstate | output | 6 | one-hot timing state, bit 0 = T1 |
| halted | output | 1 | sticky halt indication |

## Verification
The bench compares the full word in every state for each opcode, so any mistake in polarity, bit order or slot would be seen. That includes swapping the add and subtract T6 words, or loading the operand register in the accumulator's slot.

The bench also targets the halt corner. A design that advanced past T4, let the ring drift while halted, or kept the halt after clear would show the wrong tstate or halted value.

The clear release is counted edge by edge, which catches a missing or over-long reset synchroniser. Undecoded opcodes are run to confirm that they neither halt the ring nor assert any control bit.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W   = 4;
  localparam int CW_W   = 12;
  localparam int NSTATE = 6;

  // timing-state indices into the one-hot ring
  localparam int ST_T1 = 0;
  localparam int ST_T2 = 1;
  localparam int ST_T3 = 2;
  localparam int ST_T4 = 3;
  localparam int ST_T5 = 4;
  localparam int ST_T6 = 5;

  localparam logic [OP_W-1:0] OPC_LOAD = 4'b0000;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'b0001;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'b0010;
  localparam logic [OP_W-1:0] OPC_OUT  = 4'b1110;
  localparam logic [OP_W-1:0] OPC_HALT = 4'b1111;

  typedef enum logic [2:0] {
    I_LOAD, I_ADD, I_SUB, I_OUT, I_HALT, I_NOP
  } instr_e;

  // Active-high view of each control, packed from bit 11 down to bit 0.
  typedef struct packed {
    logic pc_inc;
    logic pc_drive;
    logic mar_load;
    logic mem_drive;
    logic ir_load;
    logic ir_drive;
    logic acc_load;
    logic acc_drive;
    logic alu_sub;
    logic alu_drive;
    logic breg_load;
    logic out_load;
  } ctl_act_t;

  // Ones mark pins that are active low; equals the idle word.
  localparam logic [CW_W-1:0] LOW_ACTIVE_MASK = 12'b0011_1110_0011;

  function automatic logic [CW_W-1:0] to_pins(input ctl_act_t act);
    return act ^ LOW_ACTIVE_MASK;
  endfunction
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output instr_e          instr,
  output logic            is_halt
);
  always_comb begin
    case (opcode)
      OPC_LOAD: instr = I_LOAD;
      OPC_ADD:  instr = I_ADD;
      OPC_SUB:  instr = I_SUB;
      OPC_OUT:  instr = I_OUT;
      OPC_HALT: instr = I_HALT;
      default:  instr = I_NOP;
    endcase
  end

  assign is_halt = (instr == I_HALT);
endmodule

// File: rtl/seq_ring.sv
module seq_ring
  import seq_pkg::*;
#(
  parameter int N        = NSTATE,
  parameter int HALT_IDX = ST_T4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt_dec,
  output logic [N-1:0] ring,
  output logic         halted
);
  logic [N-1:0] ring_q, ring_d;
  logic         halted_q, halted_d;
  logic         halt_req, advance_en;

  assign halt_req   = ring_q[HALT_IDX] & halt_dec;
  assign advance_en = ~halted_q & ~halt_req;

  always_comb begin
    ring_d   = ring_q;
    halted_d = halted_q | halt_req;
    if (advance_en) ring_d = {ring_q[N-2:0], ring_q[N-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q   <= N'(1);
      halted_q <= 1'b0;
    end else begin
      ring_q   <= ring_d;
      halted_q <= halted_d;
    end
  end

  assign ring   = ring_q;
  assign halted = halted_q;

  // R2: exactly one timing state is active
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == 1);

  // R2: the last state always wraps to the first
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ring_q[N-1] |=> ring_q[0]);

  // R8: halt is sticky and freezes the ring
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> (halted_q && $stable(ring_q)));

  // R8: halt only starts from the halt state with a halt opcode
  a_r8_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_q) |-> ($past(ring_q[HALT_IDX]) && $past(halt_dec) && ring_q[HALT_IDX]));
endmodule

// File: rtl/seq_ctl_rom.sv
module seq_ctl_rom
  import seq_pkg::*;
(
  input  logic [NSTATE-1:0] ring,
  input  instr_e            instr,
  input  logic              halted,
  output logic [CW_W-1:0]   word
);
  ctl_act_t act;

  always_comb begin
    act = '0;
    if (!halted) begin
      if (ring[ST_T1]) begin
        act.pc_drive = 1'b1;
        act.mar_load = 1'b1;
      end
      if (ring[ST_T2]) act.pc_inc = 1'b1;
      if (ring[ST_T3]) begin
        act.mem_drive = 1'b1;
        act.ir_load   = 1'b1;
      end
      if (ring[ST_T4]) begin
        case (instr)
          I_LOAD, I_ADD, I_SUB: begin
            act.ir_drive = 1'b1;
            act.mar_load = 1'b1;
          end
          I_OUT: begin
            act.acc_drive = 1'b1;
            act.out_load  = 1'b1;
          end
          default: ;
        endcase
      end
      if (ring[ST_T5]) begin
        case (instr)
          I_LOAD: begin
            act.mem_drive = 1'b1;
            act.acc_load  = 1'b1;
          end
          I_ADD, I_SUB: begin
            act.mem_drive = 1'b1;
            act.breg_load = 1'b1;
          end
          default: ;
        endcase
      end
      if (ring[ST_T6]) begin
        case (instr)
          I_ADD: begin
            act.alu_drive = 1'b1;
            act.acc_load  = 1'b1;
          end
          I_SUB: begin
            act.alu_drive = 1'b1;
            act.alu_sub   = 1'b1;
            act.acc_load  = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign word = to_pins(act);

  // R5: the ALU is driven onto the bus only in T6
  a_r5_alu_t6: assert #0 (!(word[2] && !ring[ST_T6]));
endmodule

// File: rtl/seq_ctrl_top.sv
module seq_ctrl_top
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  output logic [CW_W-1:0]   ctl_word,
  output logic [NSTATE-1:0] tstate,
  output logic              halted
);
  logic   rst_n_sync;
  instr_e instr;
  logic   is_halt;

  seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  seq_decode u_dec (
    .opcode  (opcode),
    .instr   (instr),
    .is_halt (is_halt)
  );

  seq_ring #(.N(NSTATE), .HALT_IDX(ST_T4)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .halt_dec (is_halt),
    .ring     (tstate),
    .halted   (halted)
  );

  seq_ctl_rom u_rom (
    .ring   (tstate),
    .instr  (instr),
    .halted (halted),
    .word   (ctl_word)
  );

  // R3: the program counter increments only in T2
  a_r3_inc_t2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ctl_word[11] |-> tstate[ST_T2]);

  // R3: the instruction register loads only in T3
  a_r3_irload_t3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !ctl_word[7] |-> tstate[ST_T3]);

  // R8: a halted sequencer asserts no control
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n_sync)
    halted |-> (ctl_word == LOW_ACTIVE_MASK));
endmodule

// File: tb/sim_seq_ctrl_top.sv
module sim_seq_ctrl_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  opcode;
  logic [11:0] ctl_word;
  logic [5:0]  tstate;
  logic        halted;

  int n_chk;
  int n_bad;
  bit done;

  localparam logic [11:0] W_IDLE = 12'h3E3;

  seq_ctrl_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .ctl_word (ctl_word),
    .tstate   (tstate),
    .halted   (halted)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_word(input logic [3:0] op, input int k);
    case (k)
      0: return 12'h5E3;
      1: return 12'hBE3;
      2: return 12'h263;
      default: ;
    endcase
    case (op)
      4'b0000: return (k == 3) ? 12'h1A3 : (k == 4) ? 12'h2C3 : W_IDLE;
      4'b0001: return (k == 3) ? 12'h1A3 : (k == 4) ? 12'h2E1 : 12'h3C7;
      4'b0010: return (k == 3) ? 12'h1A3 : (k == 4) ? 12'h2E1 : 12'h3CF;
      4'b1110: return (k == 3) ? 12'h3F2 : W_IDLE;
      default: return W_IDLE;
    endcase
  endfunction

  task automatic to_t1();
    while (tstate !== 6'b000001) @(negedge clk);
  endtask

  task automatic run_instr(input logic [3:0] op, input string tag);
    to_t1();
    opcode = op;
    for (int k = 0; k < 6; k++) begin
      chk({"R2 tstate ", tag}, tstate, 32'(6'b1 << k));
      chk(k < 3 ? {"R3 fetch word ", tag} : {tag, " exec word"}, ctl_word, exp_word(op, k));
      chk({"R10 no halt ", tag}, halted, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    chk("R1 reset tstate", tstate, 6'b000001);
    chk("R1 reset halted", halted, 0);
    chk("R1 reset word", ctl_word, 12'h5E3);
  endtask

  task automatic t_release();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 release edge1", tstate, 6'b000001);
    @(negedge clk);
    chk("R9 release edge2", tstate, 6'b000001);
    @(negedge clk);
    chk("R9 release edge3", tstate, 6'b000010);
  endtask

  task automatic t_halt();
    to_t1();
    opcode = 4'b1111;
    repeat (3) @(negedge clk);
    chk("R8 halt T4 tstate", tstate, 6'b001000);
    chk("R8 halt T4 word", ctl_word, W_IDLE);
    chk("R8 halt T4 not yet", halted, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 halted", halted, 1);
      chk("R8 frozen tstate", tstate, 6'b001000);
      chk("R8 idle word", ctl_word, W_IDLE);
    end
    opcode = 4'b0001;
    @(negedge clk);
    chk("R8 opcode change ignored", tstate, 6'b001000);
    chk("R8 stays halted", halted, 1);
  endtask

  task automatic t_clear();
    #2 rst_n = 1'b0;
    #1;
    chk("R9 clear halted", halted, 0);
    chk("R9 clear tstate", tstate, 6'b000001);
    chk("R1 async word", ctl_word, 12'h5E3);
    t_release();
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    opcode = 4'b0000;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_release();
    run_instr(4'b0000, "R4 load");
    run_instr(4'b0001, "R5 add");
    run_instr(4'b0010, "R6 sub");
    run_instr(4'b1110, "R7 out");
    run_instr(4'b0101, "R10 undef5");
    run_instr(4'b1000, "R10 undef8");
    run_instr(4'b0001, "R5 add again");
    t_halt();
    t_clear();
    run_instr(4'b0010, "R6 sub after clear");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule